// File: doc/BRIEF.md
# Dual Prescaled Periodic Interval Timer

This block holds two independent periodic timers behind a small register bus. Each timer is programmed with two 16-bit terms, a prescale term and a divide term. While both terms are nonzero the timer counts system clocks, emits a one-clock interrupt request pulse each time its period runs out, and then reloads by itself. The period is the product of the two terms, each plus one.

Software programs a timer by writing either term as a whole word or as one byte. Any write to a term restarts that timer at once from the updated values. A zero in either term stops the timer and clears its count. Both terms can be read back as a word or one byte at a time. An interrupt controller outside this block latches and masks the request pulses.

Top module: `pit_dual_timer`

## Requirements
- R1: Register map on the byte address `bus_addr`. Bit 2 selects the timer (0 = timer 1, 1 = timer 2). Bit 1 selects the term (0 = prescale, 1 = divide). Bit 0 selects the byte lane on byte accesses. The word addresses are therefore 0, 2, 4 and 6: timer 1 prescale, timer 1 divide, timer 2 prescale, timer 2 divide.
- R2: A word read (`bus_word`=1) returns the stored 16-bit term on `bus_rdata`. A byte read returns the selected byte in `bus_rdata[7:0]` with zeros above it: bits 15:8 for an even address and bits 7:0 for an odd address. Reads are combinational from the address.
- R3: A byte write (`bus_word`=0) takes its data from `bus_wdata[7:0]`. An even address updates bits 15:8 of the term and an odd address updates bits 7:0. The other byte is kept. A word write replaces all 16 bits and ignores address bit 0.
- R4: With prescale p and divide d both nonzero, the period P is (1+p)*(1+d) clocks. The first pulse appears P clocks after the clock edge that took the last write, and further pulses follow every P clocks.
- R5: If either term of a timer is zero, that timer produces no pulses and its count stays at zero.
- R6: Any write to either term of a timer, word or byte, restarts that timer's count from the new period, even if the value is unchanged. A write to one timer does not disturb the other.
- R7: Each request pulse is high for exactly one clock.
- R8: After reset, all four terms read as zero and both request outputs are low.
- R9: `irq_pulse[0]` belongs to timer 1 (request line 2 of the interrupt controller) and `irq_pulse[1]` belongs to timer 2 (line 3).
- R10: The count holds the largest period, 65536*65536, without wrapping, and never exceeds the programmed period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; timers count its rising edges |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized upstream |
| bus_sel | input | 1 | Access strobe for this block |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | input | 3 | Byte address inside the block |
| bus_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| bus_rdata | output | 16 | Read data for the current address |
| irq_pulse | output | 2 | One-clock request pulses, bit 0 timer 1, bit 1 timer 2 |

## Verification
A corrupted count shows up at the ports as a shifted pulse. It moves the first pulse after a write, or stretches or shrinks the gap between two pulses, so it becomes visible within one programmed period. A wrong enable decision shows as pulses from a timer with a zero term, or as silence from a running one, within a few clocks of the write. A byte-lane or address-decode fault shows on the very next readback, and also in the period that the timer then produces. The bench sweeps every small combination of both terms on both timers and compares the measured intervals with the arithmetic product.

// File: rtl/pit_pkg.sv
package pit_pkg;

  // term selected by address bit 1
  typedef enum logic {
    TERM_PRESCALE = 1'b0,
    TERM_DIVIDE   = 1'b1
  } pit_term_e;

  // width of a counter that can hold (2^w)*(2^w)
  function automatic int unsigned pit_cnt_width(input int unsigned reg_w);
    return 2 * reg_w + 1;
  endfunction

endpackage

// File: rtl/pit_regfile.sv
module pit_regfile
  import pit_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 2,
  parameter int unsigned REG_W      = 16,
  parameter int unsigned ADDR_W     = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bus_sel,
  input  logic                             bus_wr,
  input  logic                             bus_word,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic [REG_W-1:0]                 bus_wdata,
  output logic [REG_W-1:0]                 bus_rdata,
  output logic [NUM_TIMERS-1:0][REG_W-1:0] pre_nx,
  output logic [NUM_TIMERS-1:0][REG_W-1:0] div_nx,
  output logic [NUM_TIMERS-1:0]            load
);

  localparam int unsigned HALF   = REG_W / 2;
  localparam int unsigned TSEL_W = ADDR_W - 2;

  logic [NUM_TIMERS-1:0][REG_W-1:0] pre_q, div_q;
  logic [TSEL_W-1:0]                tsel;
  pit_term_e                        term;
  logic                             wr_en;
  logic [REG_W-1:0]                 cur_wr, new_val, cur_rd;

  assign tsel  = bus_addr[ADDR_W-1:2];
  assign term  = pit_term_e'(bus_addr[1]);
  assign wr_en = bus_sel & bus_wr;

  // next-state: merge byte lanes into the addressed term
  always_comb begin
    pre_nx = pre_q;
    div_nx = div_q;
    load   = '0;
    cur_wr  = (term == TERM_DIVIDE) ? div_q[tsel] : pre_q[tsel];
    new_val = cur_wr;
    if (bus_word) begin
      new_val = bus_wdata;
    end else if (bus_addr[0]) begin
      new_val[HALF-1:0] = bus_wdata[HALF-1:0];
    end else begin
      new_val[REG_W-1:HALF] = bus_wdata[HALF-1:0];
    end
    for (int t = 0; t < NUM_TIMERS; t++) begin
      if (wr_en && (tsel == TSEL_W'(t))) begin
        load[t] = 1'b1;
        if (term == TERM_DIVIDE) begin
          div_nx[t] = new_val;
        end else begin
          pre_nx[t] = new_val;
        end
      end
    end
  end

  // read mux
  always_comb begin
    cur_rd = (term == TERM_DIVIDE) ? div_q[tsel] : pre_q[tsel];
    if (bus_word) begin
      bus_rdata = cur_rd;
    end else if (bus_addr[0]) begin
      bus_rdata = {{(REG_W-HALF){1'b0}}, cur_rd[HALF-1:0]};
    end else begin
      bus_rdata = {{(REG_W-HALF){1'b0}}, cur_rd[REG_W-1:HALF]};
    end
  end

  // storage with explicit clock enables
  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_regs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pre_q[g] <= '0;
        div_q[g] <= '0;
      end else if (load[g]) begin
        pre_q[g] <= pre_nx[g];
        div_q[g] <= div_nx[g];
      end
    end
  end

endmodule

// File: rtl/pit_period.sv
module pit_period #(
  parameter int unsigned REG_W = 16,
  parameter int unsigned CNT_W = 33
) (
  input  logic [REG_W-1:0] pre,
  input  logic [REG_W-1:0] div,
  output logic [CNT_W-1:0] period,
  output logic             enabled
);

  logic [CNT_W-1:0] pre_p1, div_p1;

  always_comb begin
    pre_p1  = {{(CNT_W-REG_W){1'b0}}, pre} + CNT_W'(1);
    div_p1  = {{(CNT_W-REG_W){1'b0}}, div} + CNT_W'(1);
    period  = pre_p1 * div_p1;
    enabled = (|pre) & (|div);
  end

endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int unsigned CNT_W = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             enabled,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             irq
);

  logic [CNT_W-1:0] cnt_d;
  logic             irq_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt;
    irq_d = 1'b0;
    if (load) begin
      cnt_d = enabled ? period : '0;
    end else if (cnt == CNT_W'(1)) begin
      cnt_d = period;
      irq_d = 1'b1;
    end else if (cnt != '0) begin
      cnt_d = cnt - CNT_W'(1);
    end
    cnt_en = load | (cnt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      irq <= irq_d;
    end
  end

endmodule

// File: rtl/pit_dual_timer.sv
module pit_dual_timer
  import pit_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 2,
  parameter int unsigned REG_W      = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_sel,
  input  logic                              bus_wr,
  input  logic                              bus_word,
  input  logic [$clog2(NUM_TIMERS)+1:0]     bus_addr,
  input  logic [REG_W-1:0]                  bus_wdata,
  output logic [REG_W-1:0]                  bus_rdata,
  output logic [NUM_TIMERS-1:0]             irq_pulse
);

  localparam int unsigned ADDR_W = $clog2(NUM_TIMERS) + 2;
  localparam int unsigned CNT_W  = pit_cnt_width(REG_W);

  logic [NUM_TIMERS-1:0][REG_W-1:0] pre_nx, div_nx;
  logic [NUM_TIMERS-1:0]            load_all;
  logic [NUM_TIMERS-1:0]            en_all;
  logic [NUM_TIMERS-1:0][CNT_W-1:0] period_all;
  logic [NUM_TIMERS-1:0][CNT_W-1:0] cnt_all;

  pit_regfile #(
    .NUM_TIMERS(NUM_TIMERS),
    .REG_W     (REG_W),
    .ADDR_W    (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_word (bus_word),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pre_nx   (pre_nx),
    .div_nx   (div_nx),
    .load     (load_all)
  );

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
    pit_period #(
      .REG_W(REG_W),
      .CNT_W(CNT_W)
    ) u_period (
      .pre    (pre_nx[g]),
      .div    (div_nx[g]),
      .period (period_all[g]),
      .enabled(en_all[g])
    );

    pit_counter #(
      .CNT_W(CNT_W)
    ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load_all[g]),
      .enabled(en_all[g]),
      .period (period_all[g]),
      .cnt    (cnt_all[g]),
      .irq    (irq_pulse[g])
    );
  end

endmodule

// File: rtl/pit_dual_timer_chk.sv
module pit_dual_timer_chk #(
  parameter int unsigned NUM_TIMERS = 2,
  parameter int unsigned CNT_W      = 33
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_TIMERS-1:0]            irq,
  input logic [NUM_TIMERS-1:0]            load,
  input logic [NUM_TIMERS-1:0]            enabled,
  input logic [NUM_TIMERS-1:0][CNT_W-1:0] period,
  input logic [NUM_TIMERS-1:0][CNT_W-1:0] cnt
);

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chk
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |=> !irq[g]); // R7
    AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> (cnt[g] == $past(period[g]))); // R4
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!load[g] && cnt[g] > CNT_W'(1)) |=> (cnt[g] == $past(cnt[g]) - CNT_W'(1))); // R4
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!load[g] && !enabled[g]) |-> (cnt[g] == '0)); // R5
    AST_NO_PULSE_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!load[g] && cnt[g] == '0) |=> !irq[g]); // R5
    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (load[g] && enabled[g]) |=> (cnt[g] == $past(period[g]) && !irq[g])); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !load[g] |-> (cnt[g] <= period[g])); // R10
  end

endmodule

bind pit_dual_timer pit_dual_timer_chk #(
  .NUM_TIMERS(NUM_TIMERS),
  .CNT_W     (CNT_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .irq    (irq_pulse),
  .load   (load_all),
  .enabled(en_all),
  .period (period_all),
  .cnt    (cnt_all)
);

// File: tb/tb_pit_dual_timer.sv
module tb_pit_dual_timer;

  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_wr, bus_word;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [1:0]  irq_pulse;

  int checks;
  int fails;
  int seen0, seen1;
  bit done;

  pit_dual_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_pulse(irq_pulse)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (irq_pulse[0]) seen0++;
    if (irq_pulse[1]) seen1++;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // address = {timer, term, lane}
  task automatic bus_write(input int t, input int term, input bit word,
                           input bit lane, input logic [15:0] data);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_word = word;
    bus_addr = {t[0], term[0], lane};
    bus_wdata = data;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_word = 1; bus_wdata = '0;
  endtask

  task automatic read_chk(input string tag, input int t, input int term,
                          input bit word, input bit lane, input longint exp);
    bus_addr = {t[0], term[0], lane};
    bus_word = word;
    #1;
    chk(tag, longint'(bus_rdata), exp);
    bus_word = 1;
  endtask

  // negedges until a pulse on line idx; -1 when none within limit
  task automatic wait_pulse(input int idx, input int limit, output int n);
    bit found;
    found = 0;
    n = 0;
    while (!found && n < limit) begin
      @(negedge clk);
      n++;
      if (irq_pulse[idx]) found = 1;
    end
    if (!found) n = -1;
  endtask

  task automatic sweep(input int t);
    int n;
    int per;
    for (int p = 0; p < 4; p++) begin
      for (int d = 0; d < 4; d++) begin
        bus_write(t, 0, 1, 0, 16'(p));
        bus_write(t, 1, 1, 0, 16'(d));
        per = (1 + p) * (1 + d);
        if (p == 0 || d == 0) begin
          wait_pulse(t, 40, n);
          chk("R5 zero term gives no pulse", n, -1);
        end else begin
          wait_pulse(t, 200, n);
          chk("R4 first pulse delay", n, per);
          @(negedge clk);
          chk("R7 pulse width one clock", irq_pulse[t], 0);
          wait_pulse(t, 200, n);
          chk("R4 repeat interval", n + 1, per);
        end
      end
    end
  endtask

  initial begin
    int n;
    checks = 0; fails = 0; seen0 = 0; seen1 = 0; done = 0;
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_word = 1; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R8 reset state
    for (int t = 0; t < 2; t++)
      for (int r = 0; r < 2; r++)
        read_chk("R8 term zero after reset", t, r, 1, 0, 0);
    chk("R8 no request after reset", irq_pulse, 0);

    // R1 register map: distinct word per offset
    for (int k = 0; k < 4; k++) bus_write(k / 2, k % 2, 1, 0, 16'(16'h1111 * (k + 1)));
    for (int k = 0; k < 4; k++) read_chk("R1 offset map", k / 2, k % 2, 1, 0, 16'h1111 * (k + 1));
    for (int k = 0; k < 4; k++) bus_write(k / 2, k % 2, 1, 0, 16'h0000);

    // R4 R5 R7 sweep timer 1, then R9 mapping
    seen0 = 0; seen1 = 0;
    sweep(0);
    chk("R9 timer 1 never drives line of timer 2", seen1, 0);
    bus_write(0, 0, 1, 0, 16'h0000);
    repeat (2) @(negedge clk);
    seen0 = 0;
    sweep(1);
    chk("R9 timer 2 never drives line of timer 1", seen0, 0);

    // R2 R3 byte access on timer 2 prescale
    bus_write(1, 0, 1, 1, 16'h0302);
    read_chk("R2 word readback", 1, 0, 1, 0, 16'h0302);
    bus_write(1, 0, 0, 1, 16'hAA01);
    read_chk("R3 odd byte write keeps high byte", 1, 0, 1, 0, 16'h0301);
    read_chk("R2 even byte read", 1, 0, 0, 0, 16'h0003);
    read_chk("R2 odd byte read", 1, 0, 0, 1, 16'h0001);
    bus_write(1, 0, 0, 0, 16'h5500);
    read_chk("R3 even byte write keeps low byte", 1, 0, 1, 0, 16'h0001);
    bus_write(1, 1, 1, 0, 16'h0002);
    wait_pulse(1, 100, n);
    chk("R4 period after byte programming", n, 6);

    // R6 restart by byte write of unchanged value
    repeat (3) @(negedge clk);
    bus_write(1, 1, 0, 0, 16'h0000);
    read_chk("R6 unchanged value", 1, 1, 1, 0, 16'h0002);
    wait_pulse(1, 100, n);
    chk("R6 byte write restarts count", n, 6);

    // R6 other timer undisturbed
    bus_write(0, 0, 1, 0, 16'h0003);
    bus_write(0, 1, 1, 0, 16'h0003);
    repeat (5) @(negedge clk);
    bus_write(1, 1, 1, 0, 16'h0002);
    wait_pulse(0, 100, n);
    chk("R6 write to timer 2 leaves timer 1 running", n, 9);

    // R10 long periods
    bus_write(0, 0, 1, 0, 16'h00FF);
    bus_write(0, 1, 1, 0, 16'h0003);
    wait_pulse(0, 2000, n);
    chk("R10 long period 1024", n, 1024);
    bus_write(0, 0, 1, 0, 16'hFFFF);
    bus_write(0, 1, 1, 0, 16'hFFFF);
    read_chk("R10 max prescale readback", 0, 0, 1, 0, 16'hFFFF);
    wait_pulse(0, 300, n);
    chk("R10 max period does not wrap", n, -1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule